// File: doc/BRIEF.md
# ISA Capability Register Write Legaliser

This block keeps the machine's ISA capability register: one enable flag per extension letter in the low 26 bits, a base-width code in the top two bits, and zeros between them. Software writes do not land in the register as written. Each write is first judged as a whole, and the block may discard it. If the write is kept, the block masks the letter flags down to what this hart and this implementation can support. It then corrects any combination that cannot stand.

A write is discarded when any of these is true:
- the writability strap is low;
- the write names no base integer ISA;
- the write asks for the embedded base.

A kept write keeps only those letters that the per-hart supported mask and the fixed implementable set both allow. Double-precision is then dropped if single-precision did not survive. Compressed is dropped if the next instruction would sit at an address that is not a multiple of four.

The base-width code never changes after reset. Every accepted write that alters the stored value produces a one-cycle change pulse, so that surrounding logic can flush state that was derived from the old flags.

Top module: `isa_cap_reg`

## Requirements
- R1: While `wr_allow` is 0, a write (`wr_en`=1) leaves `cap_value` unchanged and no pulse follows.
- R2: A write whose data has both bit 8 (I) and bit 4 (E) clear is discarded whole: `cap_value` is unchanged.
- R3: A write whose data has bit 4 (E) set is discarded whole, whatever else it carries.
- R4: An accepted write stores letter bits equal to `wr_data[25:0] & supp_mask` restricted to the implementable set. That set is bits 0 (A), 2 (C), 3 (D), 4 (E), 5 (F), 8 (I), 12 (M), 18 (S) and 20 (U). The result is visible on `cap_value` in the cycle after the write.
- R5: If, after R4 masking, bit 3 (D) is set and bit 5 (F) is clear, bit 3 is stored as 0.
- R6: If `next_pc_b1` is 1 during an accepted write, bit 2 (C) is stored as 0.
- R7: `cap_value[31:30]` always reads 2'b01 (32-bit base) and bits 29:26 read 0. Writes to these bits have no effect.
- R8: `cap_changed` is 1 for exactly the one cycle after an accepted write whose legalised value differs from the stored value, and 0 in every other cycle.
- R9: During synchronous reset, `cap_value` loads `supp_mask` restricted to the implementable set, with the base-width code in bits 31:30, and `cap_changed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Software write request |
| wr_data | input | 32 | Requested register value |
| supp_mask | input | 26 | Letters this hart supports |
| wr_allow | input | 1 | Strap: register is writable when 1 |
| next_pc_b1 | input | 1 | Bit 1 of the following instruction address |
| cap_value | output | 32 | Stored register value |
| cap_changed | output | 1 | One-cycle pulse after the stored value changed |

## Verification
The dependency fix-up on D and the alignment fix-up on C can both act on the same write. Both rewrite the letter field after masking, so an error in the order of the fix-ups, or one fix-up masking the other, shows up only when they fire together.

The bench provokes this with a directed write that requests C and D without F while `next_pc_b1` is 1. It also produces the same case with random data, in which F is often absent and `next_pc_b1` is random. The stored value and the pulse in the following cycle are compared against a bench model that applies each rule separately.

// File: rtl/isa_cap_pkg.sv
package isa_cap_pkg;

   localparam int unsigned NUM_LETTERS = 26;
   localparam int unsigned WIDTH_FIELD = 2;

   localparam int unsigned BIT_A = 0;
   localparam int unsigned BIT_C = 2;
   localparam int unsigned BIT_D = 3;
   localparam int unsigned BIT_E = 4;
   localparam int unsigned BIT_F = 5;
   localparam int unsigned BIT_I = 8;
   localparam int unsigned BIT_M = 12;
   localparam int unsigned BIT_S = 18;
   localparam int unsigned BIT_U = 20;

   typedef logic [NUM_LETTERS-1:0] letters_t;

   function automatic letters_t default_impl_set();
      letters_t m;
      m = '0;
      m[BIT_A] = 1'b1;
      m[BIT_C] = 1'b1;
      m[BIT_D] = 1'b1;
      m[BIT_E] = 1'b1;
      m[BIT_F] = 1'b1;
      m[BIT_I] = 1'b1;
      m[BIT_M] = 1'b1;
      m[BIT_S] = 1'b1;
      m[BIT_U] = 1'b1;
      return m;
   endfunction

   function automatic logic [WIDTH_FIELD-1:0] width_code(int unsigned xlen);
      return (xlen == 64) ? 2'b10 : 2'b01;
   endfunction

endpackage

// File: rtl/isa_cap_gate.sv
module isa_cap_gate
   import isa_cap_pkg::*;
(
   input  logic wr_en,
   input  logic wr_allow,
   input  logic req_i,
   input  logic req_e,
   output logic accept
);
   logic has_base;
   logic wants_embedded;

   always_comb begin
      has_base       = req_i | req_e;
      wants_embedded = req_e;
      accept         = wr_en & wr_allow & has_base & ~wants_embedded;
   end
endmodule

// File: rtl/isa_cap_legalise.sv
module isa_cap_legalise
   import isa_cap_pkg::*;
#(
   parameter letters_t IMPL_SET    = default_impl_set(),
   parameter bit       ALIGN_CHECK = 1'b1
)(
   input  letters_t req_letters,
   input  letters_t supp_mask,
   input  logic     next_pc_b1,
   output letters_t legal_letters
);
   letters_t masked;
   letters_t dep_fixed;

   for (genvar i = 0; i < NUM_LETTERS; i++) begin : g_letter
      if (IMPL_SET[i]) begin : g_impl
         assign masked[i] = req_letters[i] & supp_mask[i];
      end else begin : g_none
         assign masked[i] = 1'b0;
      end
   end

   always_comb begin
      dep_fixed = masked;
      if (masked[BIT_D] && !masked[BIT_F]) begin
         dep_fixed[BIT_D] = 1'b0;
      end
   end

   if (ALIGN_CHECK) begin : g_align
      always_comb begin
         legal_letters = dep_fixed;
         if (next_pc_b1) begin
            legal_letters[BIT_C] = 1'b0;
         end
      end
   end else begin : g_no_align
      assign legal_letters = dep_fixed;
   end

   always_comb begin
      a_r5_d_needs_f : assert (!(legal_letters[BIT_D] && !legal_letters[BIT_F]))
         else $error("R5: D kept without F");
      a_r4_within_supp : assert ((legal_letters & ~(supp_mask & IMPL_SET)) == '0)
         else $error("R4: unsupported letter kept");
   end
endmodule

// File: rtl/isa_cap_store.sv
module isa_cap_store #(
   parameter int unsigned XLEN = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic [XLEN-1:0] next_value,
   input  logic [XLEN-1:0] reset_value,
   output logic [XLEN-1:0] value_q,
   output logic            changed_q
);
   logic differs;

   always_comb differs = (next_value != value_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_q   <= reset_value;
         changed_q <= 1'b0;
      end else begin
         changed_q <= accept & differs;
         if (accept) begin
            value_q <= next_value;
         end
      end
   end

   a_r8_pulse_means_change : assert property (@(posedge clk) disable iff (!rst_n)
      changed_q |-> (value_q != $past(value_q)))
      else $error("R8: pulse without change");
   a_r8_quiet_means_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !changed_q |-> $stable(value_q))
      else $error("R8: change without pulse");
endmodule

// File: rtl/isa_cap_reg.sv
module isa_cap_reg
   import isa_cap_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter letters_t    IMPL_SET    = default_impl_set(),
   parameter bit          ALIGN_CHECK = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [XLEN-1:0]        wr_data,
   input  logic [NUM_LETTERS-1:0] supp_mask,
   input  logic                   wr_allow,
   input  logic                   next_pc_b1,
   output logic [XLEN-1:0]        cap_value,
   output logic                   cap_changed
);
   localparam int unsigned MID_W = XLEN - WIDTH_FIELD - NUM_LETTERS;
   localparam logic [WIDTH_FIELD-1:0] WCODE = width_code(XLEN);

   initial begin : p_param_chk
      a_xlen_legal : assert (XLEN == 32 || XLEN == 64)
         else $error("XLEN must be 32 or 64");
      a_impl_has_base : assert (IMPL_SET[BIT_I])
         else $error("implementable set must contain I");
   end

   logic     accept;
   letters_t legal_letters;
   logic [XLEN-1:0] next_value;
   logic [XLEN-1:0] reset_value;

   isa_cap_gate u_gate (
      .wr_en    (wr_en),
      .wr_allow (wr_allow),
      .req_i    (wr_data[BIT_I]),
      .req_e    (wr_data[BIT_E]),
      .accept   (accept)
   );

   isa_cap_legalise #(
      .IMPL_SET    (IMPL_SET),
      .ALIGN_CHECK (ALIGN_CHECK)
   ) u_legal (
      .req_letters   (wr_data[NUM_LETTERS-1:0]),
      .supp_mask     (supp_mask),
      .next_pc_b1    (next_pc_b1),
      .legal_letters (legal_letters)
   );

   assign next_value  = {WCODE, {MID_W{1'b0}}, legal_letters};
   assign reset_value = {WCODE, {MID_W{1'b0}}, supp_mask & IMPL_SET};

   isa_cap_store #(.XLEN(XLEN)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .next_value  (next_value),
      .reset_value (reset_value),
      .value_q     (cap_value),
      .changed_q   (cap_changed)
   );

   a_r1_strap_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_allow) |=> ($stable(cap_value) && !cap_changed))
      else $error("R1: write passed with strap low");
   a_r2_needs_base : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[BIT_I] && !wr_data[BIT_E]) |=> $stable(cap_value))
      else $error("R2: write without base stored");
   a_r3_no_embedded : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_E]) |=> $stable(cap_value))
      else $error("R3: embedded write stored");
   a_r6_c_alignment : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && next_pc_b1 && ALIGN_CHECK) |=> !cap_value[BIT_C])
      else $error("R6: C kept while misaligned");
   a_r7_width_fixed : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(cap_value[XLEN-1 -: WIDTH_FIELD]))
      else $error("R7: width field moved");
endmodule

// File: tb/isa_cap_reg_tb.sv
module isa_cap_reg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [25:0] supp_mask = '0;
   logic        wr_allow = 1'b0;
   logic        next_pc_b1 = 1'b0;
   logic [31:0] cap_value;
   logic        cap_changed;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;
   logic [31:0] model;

   localparam logic [25:0] IMPL = 26'h014113D;

   always #(CLK_PERIOD/2) clk = ~clk;

   isa_cap_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .supp_mask(supp_mask), .wr_allow(wr_allow), .next_pc_b1(next_pc_b1),
      .cap_value(cap_value), .cap_changed(cap_changed)
   );

   function automatic logic [31:0] legal_next(logic [31:0] old, logic allow,
         logic [31:0] d, logic [25:0] supp, logic b1);
      logic [25:0] l;
      if (!allow) return old;                 // R1
      if (!d[8] && !d[4]) return old;         // R2
      if (d[4]) return old;                   // R3
      l = d[25:0] & supp & IMPL;              // R4
      if (l[3] && !l[5]) l[3] = 1'b0;         // R5
      if (b1) l[2] = 1'b0;                    // R6
      return {2'b01, 4'b0000, l};             // R7
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic do_write(string tag, logic allow, logic [31:0] d,
         logic [25:0] supp, logic b1);
      logic [31:0] exp;
      exp        = legal_next(model, allow, d, supp, b1);
      wr_en      = 1'b1;
      wr_allow   = allow;
      wr_data    = d;
      supp_mask  = supp;
      next_pc_b1 = b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk({tag, " value"}, cap_value, exp);
      chk({tag, " pulse R8"}, {31'd0, cap_changed}, {31'd0, exp != model});
      model = exp;
   endtask

   initial begin : p_watchdog
      for (int i = 0; i < WATCHDOG; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : p_main
      logic [25:0] full;
      logic [31:0] rv;
      void'($urandom(32'd20240611));
      full      = 26'h3FFFFFF;
      supp_mask = 26'h0141129;          // A,D,F,I,M,S,U (no C, no E)
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model = {2'b01, 4'b0, 26'h0141129 & IMPL};
      // R9 reset value and quiet pulse
      chk("R9 reset value", cap_value, model);
      chk("R9 reset pulse", {31'd0, cap_changed}, 32'd0);

      // R1 strap low discards
      do_write("R1 strap low", 1'b0, 32'h0000_0101, full, 1'b0);
      // R2 no base letter
      do_write("R2 no base", 1'b1, 32'h0000_1001, full, 1'b0);
      // R3 embedded base requested
      do_write("R3 embedded", 1'b1, 32'h0000_0110, full, 1'b0);
      // R4 masking by supp and implementable set
      do_write("R4 mask", 1'b1, 32'h03FF_FFEF, 26'h0000_F1F, 1'b0);
      // R5 D without F
      do_write("R5 D no F", 1'b1, 32'h0000_0108, full, 1'b0);
      // R6 C misaligned, then aligned
      do_write("R6 C misaligned", 1'b1, 32'h0000_0104, full, 1'b1);
      do_write("R6 C aligned", 1'b1, 32'h0000_0104, full, 1'b0);
      // R7 attempt to change width and middle bits
      do_write("R7 top bits", 1'b1, 32'hFC00_0104, full, 1'b0);
      // R8 same value again: no pulse
      do_write("R8 rewrite same", 1'b1, 32'h0000_0104, full, 1'b0);
      // R5 and R6 in the same write
      do_write("R5 R6 together", 1'b1, 32'h0000_010D, full, 1'b1);
      // R8 idle cycle after a change: pulse must drop
      do_write("R4 full set", 1'b1, 32'h0014_112F, full, 1'b0);
      @(negedge clk);
      chk("R8 idle pulse", {31'd0, cap_changed}, 32'd0);
      chk("R8 idle value", cap_value, model);

      // random mix
      for (int n = 0; n < 400; n++) begin
         rv = $urandom();
         if (($urandom() % 4) != 0) begin
            rv[8] = 1'b1;
            rv[4] = 1'b0;
         end
         do_write("R4 random", ($urandom() % 8) != 0, rv,
                  (($urandom() % 4) == 0) ? 26'($urandom()) : full,
                  1'($urandom()));
      end

      // R9 reset again with a different mask
      rst_n     = 1'b0;
      supp_mask = 26'h3FFFFFF;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model = {2'b01, 4'b0, IMPL};
      chk("R9 second reset", cap_value, model);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule